// File: doc/BRIEF.md
# Serial Configuration Loader

This block configures a programmable target device over a slave-serial link. Software or a storage reader hands it a configuration image as a stream of bytes with a valid/ready handshake and announces the total byte count when it pulses `start`. The block then runs the whole configuration sequence on its own. It resets the target by pulsing the active-low program line. It waits for the target to erase itself and confirms that the target's done line is still low. It throws away the image header, clocks the payload out bit by bit, and adds a few trailing clocks so the target can finish starting up. After a settling wait it reads the done line again.

The outcome is reported as a single result flag that persists until the next load: `done_ok` when the target reported completion, or `error` when any check failed. `busy` is high for the whole sequence. The length of the program pulse, the erase wait, the final wait, and the high and low phases of the configuration clock are all parameters counted in system clock cycles. The target's done line is treated as asynchronous and is resynchronized inside the block.

Top module: `sercfg_loader`

## Requirements
- R1: After reset and whenever `busy` is low, `cfg_prog_n` is 1, `cfg_clk` is 0 and `cfg_din` is 0, and after reset `done_ok`, `error` and `in_ready` are 0.
- R2: A `start` pulse seen while `busy` is low drives `cfg_prog_n` low for exactly PROG_LOW_CYC cycles and then releases it. A `start` pulse while `busy` is high has no effect.
- R3: No byte is accepted for at least CLEAR_CYC cycles after `cfg_prog_n` rises. If the synchronized done line is high at the end of that wait, the load ends with `error`=1, no byte is accepted and no `cfg_clk` pulse is issued.
- R4: Accepted bytes that come before the first byte equal to 8'hFF are consumed without producing any `cfg_clk` pulse. The header bytes count toward `byte_count`.
- R5: The first 8'hFF byte, and every later byte up to `byte_count` bytes in total, is shifted out most-significant bit first. Each bit is the `cfg_din` value at a rising edge of `cfg_clk`.
- R6: `cfg_din` changes only while `cfg_clk` is low. Each high phase of `cfg_clk` lasts exactly CCLK_HI_CYC cycles, and each rising edge follows at least CCLK_LO_CYC low cycles.
- R7: After the last payload bit, exactly STARTUP_CLKS further `cfg_clk` pulses are issued, with `cfg_din` held at the value of the last payload bit.
- R8: At least FINAL_CYC cycles after the last `cfg_clk` fall, the synchronized done line is sampled. If it is high, `done_ok` is set; if it is low, `error` is set. Only one of the two is ever set, and `busy` then drops.
- R9: If `byte_count` bytes run out before an 8'hFF byte appears (this includes a count of 0), the load ends with `error`=1 and no `cfg_clk` pulse.
- R10: `in_ready` is high only during header skip or payload, only while no bit transfer is in progress and only while bytes remain. A start that is accepted clears `done_ok` and `error`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (taken only while idle) |
| byte_count | input | CNT_W | Total image bytes including header, latched at start |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | Image byte is valid |
| in_ready | output | 1 | Block takes the byte this cycle when valid |
| cfg_prog_n | output | 1 | Active-low program/reset line to the target |
| cfg_clk | output | 1 | Configuration clock to the target |
| cfg_din | output | 1 | Serial configuration data to the target |
| cfg_done | input | 1 | Target's done line (asynchronous) |
| busy | output | 1 | Load sequence in progress |
| done_ok | output | 1 | Last load completed with done high |
| error | output | 1 | Last load failed |

## Verification
The bench models a target that records `cfg_din` on every `cfg_clk` rising edge. It raises its done line only once the expected number of pulses has arrived. The bench targets images with and without a header, images with no 8'hFF byte, a zero byte count, a target whose done line is already high after erase, and a second start pulse in the middle of a load. A design that started shifting at the byte after 8'hFF, or that shifted header bytes, would show a mismatched bit stream. A wrong number of startup pulses, or a data change during a high phase, would show up in the pulse count and the phase timing. Skipping a done check would leave `done_ok` set where `error` is expected. A design that restarted on a `start` taken while busy would produce a second program pulse.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_PROG,
        LD_CLEAR,
        LD_SKIP,
        LD_SHIFT,
        LD_STARTUP,
        LD_FINAL
    } ld_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        logic prog_n;
        logic cclk;
        logic din;
    } cfg_lines_t;

    function automatic logic is_sync(input logic [7:0] b);
        return b == SYNC_BYTE;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sercfg_sync2.sv
module sercfg_sync2 (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/sercfg_timer.sv
module sercfg_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - W'(1);
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter
    import sercfg_pkg::*;
#(
    parameter int TW     = 8,
    parameter int NB_W   = 4,
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            shift_en,
    input  logic [7:0]      data,
    input  logic [NB_W-1:0] nbits,
    output logic            idle,
    output logic            cclk,
    output logic            din
);
    phase_e          ph;
    logic [7:0]      sr;
    logic [NB_W-1:0] left;
    logic            shen;
    logic            t_load;
    logic [TW-1:0]   t_val;
    logic            t_zero;

    sercfg_timer #(.W(TW)) u_ph_tmr (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    always_comb begin
        t_load = 1'b0;
        t_val  = TW'(LO_CYC);
        unique case (ph)
            PH_IDLE: t_load = load;
            PH_LOW: begin
                t_load = t_zero;
                t_val  = TW'(HI_CYC);
            end
            PH_HIGH: t_load = t_zero && (left != NB_W'(1));
            default: t_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph   <= PH_IDLE;
            sr   <= '0;
            left <= '0;
            shen <= 1'b0;
            cclk <= 1'b0;
            din  <= 1'b0;
        end else begin
            unique case (ph)
                PH_IDLE: if (load) begin
                    ph   <= PH_LOW;
                    sr   <= data;
                    left <= nbits;
                    shen <= shift_en;
                    if (shift_en) din <= data[7];
                end
                PH_LOW: if (t_zero) begin
                    cclk <= 1'b1;
                    ph   <= PH_HIGH;
                end
                PH_HIGH: if (t_zero) begin
                    cclk <= 1'b0;
                    if (left == NB_W'(1)) begin
                        ph <= PH_IDLE;
                    end else begin
                        left <= left - NB_W'(1);
                        ph   <= PH_LOW;
                        if (shen) begin
                            din <= sr[6];
                            sr  <= {sr[6:0], 1'b0};
                        end
                    end
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end

    assign idle = (ph == PH_IDLE);
endmodule

// File: rtl/sercfg_loader.sv
module sercfg_loader
    import sercfg_pkg::*;
#(
    parameter int CNT_W        = 16,
    parameter int PROG_LOW_CYC = 4,
    parameter int CLEAR_CYC    = 50,
    parameter int FINAL_CYC    = 100,
    parameter int CCLK_HI_CYC  = 2,
    parameter int CCLK_LO_CYC  = 2,
    parameter int STARTUP_CLKS = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] byte_count,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             cfg_prog_n,
    output logic             cfg_clk,
    output logic             cfg_din,
    input  logic             cfg_done,
    output logic             busy,
    output logic             done_ok,
    output logic             error
);
    localparam int MAX_WAIT = max2(max2(PROG_LOW_CYC, CLEAR_CYC),
                                   max2(FINAL_CYC, max2(CCLK_HI_CYC, CCLK_LO_CYC)));
    localparam int TMR_W = $clog2(MAX_WAIT + 1);
    localparam int NB_W  = $clog2(max2(8, STARTUP_CLKS) + 1);

    ld_state_e        st;
    logic [CNT_W-1:0] rem;
    logic             done_s;
    logic             accept;
    logic             t_load, t_zero;
    logic [TMR_W-1:0] t_val;
    logic             sh_load, sh_shift, sh_idle, sh_cclk, sh_din;
    logic [NB_W-1:0]  sh_nbits;
    cfg_lines_t       lines;

    sercfg_sync2 u_done_sync (.clk(clk), .rst(rst), .d(cfg_done), .q(done_s));

    sercfg_timer #(.W(TMR_W)) u_seq_tmr (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .zero(t_zero)
    );

    sercfg_shifter #(
        .TW(TMR_W), .NB_W(NB_W), .LO_CYC(CCLK_LO_CYC), .HI_CYC(CCLK_HI_CYC)
    ) u_shift (
        .clk(clk), .rst(rst), .load(sh_load), .shift_en(sh_shift),
        .data(in_data), .nbits(sh_nbits), .idle(sh_idle),
        .cclk(sh_cclk), .din(sh_din)
    );

    assign in_ready = ((st == LD_SKIP) || (st == LD_SHIFT)) && sh_idle && (rem != '0);
    assign accept   = in_valid && in_ready;

    always_comb begin
        sh_load  = 1'b0;
        sh_shift = accept;
        sh_nbits = accept ? NB_W'(8) : NB_W'(STARTUP_CLKS);
        if (accept && ((st == LD_SHIFT) || is_sync(in_data))) begin
            sh_load = 1'b1;
        end else if ((st == LD_SHIFT) && sh_idle && (rem == '0)) begin
            sh_load = 1'b1;
        end
    end

    always_comb begin
        t_load = 1'b0;
        t_val  = TMR_W'(PROG_LOW_CYC);
        unique case (st)
            LD_IDLE: t_load = start;
            LD_PROG: begin
                t_load = t_zero;
                t_val  = TMR_W'(CLEAR_CYC);
            end
            LD_STARTUP: begin
                t_load = sh_idle;
                t_val  = TMR_W'(FINAL_CYC);
            end
            default: t_load = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= LD_IDLE;
            rem     <= '0;
            done_ok <= 1'b0;
            error   <= 1'b0;
        end else begin
            unique case (st)
                LD_IDLE: if (start) begin
                    st      <= LD_PROG;
                    rem     <= byte_count;
                    done_ok <= 1'b0;
                    error   <= 1'b0;
                end
                LD_PROG: if (t_zero) st <= LD_CLEAR;
                LD_CLEAR: if (t_zero) begin
                    if (done_s) begin
                        error <= 1'b1;
                        st    <= LD_IDLE;
                    end else begin
                        st <= LD_SKIP;
                    end
                end
                LD_SKIP: begin
                    if (rem == '0) begin
                        error <= 1'b1;
                        st    <= LD_IDLE;
                    end else if (accept) begin
                        rem <= rem - CNT_W'(1);
                        if (is_sync(in_data)) st <= LD_SHIFT;
                    end
                end
                LD_SHIFT: begin
                    if (accept) rem <= rem - CNT_W'(1);
                    else if (sh_idle && (rem == '0)) st <= LD_STARTUP;
                end
                LD_STARTUP: if (sh_idle) st <= LD_FINAL;
                LD_FINAL: if (t_zero) begin
                    if (done_s) done_ok <= 1'b1;
                    else        error   <= 1'b1;
                    st <= LD_IDLE;
                end
                default: st <= LD_IDLE;
            endcase
        end
    end

    always_comb begin
        lines.prog_n = (st != LD_PROG);
        lines.cclk   = sh_cclk;
        lines.din    = sh_din && ((st == LD_SHIFT) || (st == LD_STARTUP));
    end

    assign cfg_prog_n = lines.prog_n;
    assign cfg_clk    = lines.cclk;
    assign cfg_din    = lines.din;
    assign busy       = (st != LD_IDLE);
endmodule

// File: rtl/sercfg_loader_chk.sv
module sercfg_loader_chk (
    input logic clk,
    input logic rst,
    input logic in_ready,
    input logic cfg_prog_n,
    input logic cfg_clk,
    input logic cfg_din,
    input logic busy,
    input logic done_ok,
    input logic error
);
    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (cfg_prog_n && !cfg_clk && !cfg_din)); // R1

    AST_NO_CLK_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_n |-> !cfg_clk); // R2

    AST_NO_READY_IN_PROG: assert property (@(posedge clk) disable iff (rst)
        !cfg_prog_n |-> !in_ready); // R3

    AST_DIN_HOLD_HIGH: assert property (@(posedge clk) disable iff (rst)
        (cfg_clk && $past(cfg_clk)) |-> $stable(cfg_din)); // R6

    AST_RESULT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_ok && error)); // R8

    AST_READY_GATED: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (busy && !cfg_clk)); // R10

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!done_ok && !error)); // R10
endmodule

bind sercfg_loader sercfg_loader_chk u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .cfg_prog_n(cfg_prog_n),
    .cfg_clk(cfg_clk), .cfg_din(cfg_din), .busy(busy),
    .done_ok(done_ok), .error(error)
);

// File: tb/sim_sercfg_loader.sv
`timescale 1ns/1ps
module sim_sercfg_loader;
    localparam int CNT_W = 16;
    localparam int PROG = 4;
    localparam int CLR  = 50;
    localparam int FIN  = 100;
    localparam int HI   = 2;
    localparam int LO   = 2;
    localparam int SUC  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [7:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready, cfg_prog_n, cfg_clk, cfg_din, busy, done_ok, error;
    logic cfg_done;
    logic force_done = 1'b0;
    logic late_done  = 1'b0;
    logic auto_en = 1'b0;
    int   auto_target = 0;
    logic mon_clr = 1'b0;

    always #4 clk = ~clk;
    assign cfg_done = force_done | late_done;

    sercfg_loader #(
        .CNT_W(CNT_W), .PROG_LOW_CYC(PROG), .CLEAR_CYC(CLR), .FINAL_CYC(FIN),
        .CCLK_HI_CYC(HI), .CCLK_LO_CYC(LO), .STARTUP_CLKS(SUC)
    ) u0 (
        .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .cfg_prog_n(cfg_prog_n), .cfg_clk(cfg_clk), .cfg_din(cfg_din),
        .cfg_done(cfg_done), .busy(busy), .done_ok(done_ok), .error(error)
    );

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    // target model and line monitor
    bit capt [0:511];
    int rises, prog_low, prog_falls, gap, hi_bad, lo_bad, hi_len, lo_len, fin_gap, ready_bad;
    bit seen_ready, prev_c, prev_p, prev_d;

    always @(negedge clk) begin
        if (mon_clr) begin
            rises = 0; prog_low = 0; prog_falls = 0; gap = 0; hi_bad = 0; lo_bad = 0;
            hi_len = 0; lo_len = 0; fin_gap = 0; ready_bad = 0; seen_ready = 0;
            prev_c = 0; prev_p = 1; prev_d = 0; late_done = 1'b0;
        end else begin
            if (!cfg_prog_n) prog_low++;
            if (prev_p && !cfg_prog_n) prog_falls++;
            if (in_ready && (!cfg_prog_n || cfg_clk)) ready_bad++;
            if (busy && cfg_prog_n && !seen_ready && rises == 0) begin
                if (in_ready) seen_ready = 1;
                else if (prog_falls > 0) gap++;
            end
            if (cfg_clk && !prev_c) begin
                if (rises < 512) capt[rises] = cfg_din;
                rises++;
                if (lo_len < LO) lo_bad++;
            end
            if (cfg_clk) begin
                hi_len++;
                if (prev_c && cfg_din != prev_d) hi_bad++;
            end else begin
                if (prev_c) begin
                    if (hi_len != HI) hi_bad++;
                    hi_len = 0; lo_len = 0; fin_gap = 0;
                end
                lo_len++;
                if (busy && rises > 0) fin_gap++;
            end
            if (auto_en && rises == auto_target && !cfg_clk) late_done = 1'b1;
            prev_c = cfg_clk; prev_p = cfg_prog_n; prev_d = cfg_din;
        end
    end

    logic [7:0] img [0:31];
    int accepted;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic run_load(input int n, input bit pre, input bit fin, input bit extra);
        int p;
        int nb;
        bit did;
        bit acc;
        p = n;
        for (int i = n - 1; i >= 0; i--) if (img[i] == 8'hFF) p = i;
        nb = (n - p) * 8;
        mon_clr = 1'b1;
        force_done = pre;
        auto_en = fin;
        auto_target = nb + SUC;
        byte_count = CNT_W'(n);
        tick();
        mon_clr = 1'b0;
        tick();
        start = 1'b1;
        tick();
        start = 1'b0;
        chk(!done_ok && !error, "R10", "results cleared at start", {done_ok, error}, 0);
        accepted = 0;
        did = 0;
        for (int c = 0; c < 20000 && busy; c++) begin
            in_valid = (accepted < n);
            in_data  = img[accepted];
            acc = in_valid && in_ready;
            start = extra && !did && rises > 3;
            if (start) did = 1;
            tick();
            start = 1'b0;
            if (acc) accepted++;
        end
        in_valid = 1'b0;
        tick();
        chk(prog_falls == 1, "R2", "program pulses", prog_falls, 1);
        chk(ready_bad == 0, "R10", "ready while prog or clk high", ready_bad, 0);
        if (pre || p == n) begin
            chk(error && !done_ok, "R9", "error result", error, 1);
            chk(rises == 0, pre ? "R3" : "R9", "no clock pulses", rises, 0);
            chk(accepted == (pre ? 0 : n), pre ? "R3" : "R9", "bytes taken",
                accepted, pre ? 0 : n);
        end else begin
            chk(prog_low == PROG, "R2", "program low width", prog_low, PROG);
            chk(gap >= CLR, "R3", "erase wait before first ready", gap, CLR);
            chk(accepted == n, "R4", "all bytes consumed", accepted, n);
            chk(rises == nb + SUC, "R5", "clock pulse count", rises, nb + SUC);
            for (int b = 0; b < nb; b++) begin
                bit e;
                e = img[p + b / 8][7 - (b % 8)];
                if (capt[b] != e) chk(0, "R5", $sformatf("bit %0d", b), capt[b], e);
            end
            chk(1, "R5", "bit stream compared", 0, 0);
            for (int s = 0; s < SUC; s++)
                chk(capt[nb + s] == capt[nb - 1], "R7", "startup din held",
                    capt[nb + s], capt[nb - 1]);
            chk(hi_bad == 0 && lo_bad == 0, "R6", "phase timing errors", hi_bad + lo_bad, 0);
            chk(fin_gap >= FIN, "R8", "final wait", fin_gap, FIN);
            chk(done_ok == fin && error == !fin, "R8", "result done_ok", done_ok, fin);
        end
        chk(!busy && cfg_prog_n && !cfg_clk && !cfg_din, "R1", "idle lines after load",
            {busy, cfg_prog_n, cfg_clk, cfg_din}, 3'b100);
    endtask

    task automatic t_reset();
        chk(cfg_prog_n && !cfg_clk && !cfg_din, "R1", "reset lines",
            {cfg_prog_n, cfg_clk, cfg_din}, 3'b100);
        chk(!busy && !done_ok && !error && !in_ready, "R1", "reset flags",
            {busy, done_ok, error, in_ready}, 0);
    endtask

    task automatic t_header_ok();
        img[0] = 8'h12; img[1] = 8'h00; img[2] = 8'hAB; img[3] = 8'hFF;
        img[4] = 8'h5A; img[5] = 8'hC3; img[6] = 8'h01;
        run_load(7, 1'b0, 1'b1, 1'b1);   // R4, R5 with a mid-load start (R2)
    endtask

    task automatic t_no_header_fail();
        img[0] = 8'hFF; img[1] = 8'h80; img[2] = 8'h7E;
        run_load(3, 1'b0, 1'b0, 1'b0);   // R8 done stays low
    endtask

    task automatic t_done_early();
        img[0] = 8'hFF; img[1] = 8'h55;
        run_load(2, 1'b1, 1'b0, 1'b0);   // R3 done high after erase
        force_done = 1'b0;
    endtask

    task automatic t_no_sync();
        img[0] = 8'h11; img[1] = 8'h22;
        run_load(2, 1'b0, 1'b0, 1'b0);   // R9
    endtask

    task automatic t_zero_count();
        img[0] = 8'hFF;
        run_load(0, 1'b0, 1'b0, 1'b0);   // R9 empty image
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_header_ok();
        t_no_header_fail();
        t_done_early();
        t_no_sync();
        t_zero_count();
        t_header_ok();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule